// File: doc/BRIEF.md
# Two-Way Interleaved Slow Unit

This block wraps a slow combinational function so that, from the outside, it looks like a pipelined unit that takes one operand and returns one result on every clock. Pipeline registers cannot be placed inside the function's logic. Instead the block holds two identical copies of it and hands successive valid operands to the copies in turn. Each copy keeps its operand in a private register for two full clock cycles, which gives the function a two-cycle settling window. A select tag travels alongside each operand and tells the output multiplexer which copy to sample once that window has closed.

An operand is accepted on rising edge k when `in_valid` is high. Its result is written into the output register on edge k+2, so it is visible from edge k+2 until the next result replaces it. Gaps in `in_valid` are allowed. A gap does not advance the steering toggle, so only valid operands count toward the alternation.

The function is picked at elaboration time. The default variant is a quadratic, y = x*x + MUL_K*x + ADD_K taken modulo 2^W. The second variant is a chain of ROUNDS rotate-and-add mixing steps. The width and all constants are parameters.

Top module: `ilv2_slow_unit`

## Requirements
- R1: With the default parameters (W=16, quadratic variant, MUL_K=37, ADD_K=0x1234), each result equals (x*x + 37*x + 0x1234) mod 65536, where x is the operand accepted.
- R2: While `rst` is high on a rising edge, `out_valid` and `out_data` are cleared to 0 and the steering toggle is cleared so that the next valid operand goes to copy 0. Operands still in flight at that edge produce no result.
- R3: Valid operands are steered to copy 0 and copy 1 in strict alternation, starting from copy 0 after reset. A cycle with `in_valid` low loads no copy and leaves the toggle unchanged.
- R4: An operand accepted on edge k makes `out_valid` high after edge k+2. After every edge, `out_valid` equals the `in_valid` value sampled two edges earlier. A new operand can be accepted on every edge.
- R5: Results leave in the same order as the operands entered, both for back-to-back operands and for operands separated by gaps of any length.
- R6: A copy's operand register changes only on an edge where that copy is loaded. After a load, the register keeps its value for at least two cycles.
- R7: When `out_valid` is low, `out_data` keeps the last result delivered, or 0 if there has been none since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand on `in_data` is accepted at this edge |
| in_data | input | W | Operand |
| out_valid | output | 1 | `out_data` holds a new result this cycle |
| out_data | output | W | Registered result |

## Verification
On every cycle, the bound checker enforces the steering rules: exactly one copy is loaded per valid operand, the toggle flips only on valid cycles, and an operand register stays unchanged off its turn and for two cycles after a load. It also checks the fixed two-edge distance between `in_valid` and `out_valid`, and that `out_data` holds steady through gaps. Only the bench scenarios can show that the values are correct and arrive in order. They compare results against an independent model of the function for boundary operands, for long back-to-back bursts in which both copies are busy, for irregular gap patterns, and for a reset that discards operands in flight.

// File: rtl/ilv2_pkg.sv
package ilv2_pkg;
   localparam int ILV2_WAYS = 2;
   localparam int FN_POLY   = 0;
   localparam int FN_MIX    = 1;

   typedef struct packed {
      logic vld;
      logic way;
   } ilv2_tag_t;
endpackage

// File: rtl/ilv2_slow_func.sv
module ilv2_slow_func
   import ilv2_pkg::*;
#(
   parameter int W      = 16,
   parameter int KIND   = FN_POLY,
   parameter int MUL_K  = 37,
   parameter int ADD_K  = 4660,
   parameter int ROUNDS = 3
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] ADD_W = W'(ADD_K);

   if (KIND == FN_POLY) begin : g_poly
      localparam logic [W-1:0] MUL_W = W'(MUL_K);
      logic [2*W-1:0] sq;
      logic [2*W-1:0] lin;
      always_comb begin
         sq = a * a;
         lin = a * MUL_W;
         y = sq[W-1:0] + lin[W-1:0] + ADD_W;
      end
   end else begin : g_mix
      logic [ROUNDS:0][W-1:0] st;
      assign st[0] = a;
      for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
         assign st[r+1] = {st[r][W-4:0], st[r][W-1:W-3]} ^ (st[r] + ADD_W);
      end
      assign y = st[ROUNDS];
   end
endmodule

// File: rtl/ilv2_way.sv
module ilv2_way
   import ilv2_pkg::*;
#(
   parameter int W      = 16,
   parameter int KIND   = FN_POLY,
   parameter int MUL_K  = 37,
   parameter int ADD_K  = 4660,
   parameter int ROUNDS = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] op,
   output logic [W-1:0] res
);
   always_ff @(posedge clk) begin
      if (rst)
         op <= '0;
      else if (load)
         op <= din;
   end

   ilv2_slow_func #(
      .W(W), .KIND(KIND), .MUL_K(MUL_K), .ADD_K(ADD_K), .ROUNDS(ROUNDS)
   ) u_func (
      .a(op),
      .y(res)
   );
endmodule

// File: rtl/ilv2_steer.sv
module ilv2_steer
   import ilv2_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   output logic                 nxt_way,
   output logic [ILV2_WAYS-1:0] way_load,
   output logic                 sel_vld,
   output logic                 sel_way
);
   ilv2_tag_t tag1, tag2;

   always_comb begin
      way_load = '0;
      if (in_valid)
         way_load[nxt_way] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         nxt_way <= 1'b0;
         tag1    <= '0;
         tag2    <= '0;
      end else begin
         if (in_valid)
            nxt_way <= ~nxt_way;
         tag1 <= '{vld: in_valid, way: nxt_way};
         tag2 <= tag1;
      end
   end

   assign sel_vld = tag2.vld;
   assign sel_way = tag2.way;
endmodule

// File: rtl/ilv2_slow_unit.sv
module ilv2_slow_unit
   import ilv2_pkg::*;
#(
   parameter int W         = 16,
   parameter int FUNC_KIND = FN_POLY,
   parameter int MUL_K     = 37,
   parameter int ADD_K     = 4660,
   parameter int ROUNDS    = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   if (W < 4) begin : g_bad_w
      $error("ilv2_slow_unit: W must be at least 4");
   end
   if (FUNC_KIND != FN_POLY && FUNC_KIND != FN_MIX) begin : g_bad_kind
      $error("ilv2_slow_unit: unknown FUNC_KIND");
   end
   if (ROUNDS < 1 || ROUNDS > 16) begin : g_bad_rounds
      $error("ilv2_slow_unit: ROUNDS must be within 1..16");
   end

   logic                          nxt_way;
   logic [ILV2_WAYS-1:0]          way_load;
   logic                          sel_vld;
   logic                          sel_way;
   logic [ILV2_WAYS-1:0][W-1:0]   way_op;
   logic [ILV2_WAYS-1:0][W-1:0]   way_res;

   ilv2_steer u_steer (
      .clk(clk),
      .rst(rst),
      .in_valid(in_valid),
      .nxt_way(nxt_way),
      .way_load(way_load),
      .sel_vld(sel_vld),
      .sel_way(sel_way)
   );

   for (genvar g = 0; g < ILV2_WAYS; g++) begin : g_way
      ilv2_way #(
         .W(W), .KIND(FUNC_KIND), .MUL_K(MUL_K), .ADD_K(ADD_K), .ROUNDS(ROUNDS)
      ) u_way (
         .clk(clk),
         .rst(rst),
         .load(way_load[g]),
         .din(in_data),
         .op(way_op[g]),
         .res(way_res[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= sel_vld;
         if (sel_vld)
            out_data <= way_res[sel_way];
      end
   end
endmodule

// File: rtl/ilv2_slow_unit_chk.sv
module ilv2_slow_unit_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic         out_valid,
   input logic [W-1:0] out_data,
   input logic         nxt_way,
   input logic [1:0]   way_load,
   input logic [W-1:0] op0,
   input logic [W-1:0] op1
);
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst)
         age <= '0;
      else if (age != 2'd3)
         age <= age + 2'd1;
   end

   a_r2_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0 && !nxt_way));

   a_r3_toggle_flips: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> nxt_way != $past(nxt_way));

   a_r3_toggle_holds: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(nxt_way));

   a_r3_one_copy: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ($countones(way_load) == 1 && way_load[nxt_way]));

   a_r3_idle_no_load: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> way_load == 2'b00);

   a_r6_op0_own_turn: assert property (@(posedge clk) disable iff (rst)
      !way_load[0] |=> $stable(op0));

   a_r6_op1_own_turn: assert property (@(posedge clk) disable iff (rst)
      !way_load[1] |=> $stable(op1));

   a_r6_op0_two_cycles: assert property (@(posedge clk) disable iff (rst)
      way_load[0] |=> ##1 $stable(op0));

   a_r6_op1_two_cycles: assert property (@(posedge clk) disable iff (rst)
      way_load[1] |=> ##1 $stable(op1));

   a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3) |-> out_valid == $past(in_valid, 3));

   a_r7_hold_in_gap: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && !out_valid) |-> $stable(out_data));
endmodule

bind ilv2_slow_unit ilv2_slow_unit_chk #(.W(W)) u_chk (
   .clk(clk),
   .rst(rst),
   .in_valid(in_valid),
   .out_valid(out_valid),
   .out_data(out_data),
   .nxt_way(nxt_way),
   .way_load(way_load),
   .op0(way_op[0]),
   .op1(way_op[1])
);

// File: tb/ilv2_slow_unit_tb_top.sv
module ilv2_slow_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam int NSTIM = 16;
   // MSB = valid, low 16 bits = operand
   localparam logic [W:0] STIM [NSTIM] = '{
      17'h1_0000, 17'h1_FFFF, 17'h1_0001, 17'h0_0000,
      17'h1_8000, 17'h1_1234, 17'h1_ABCD, 17'h0_0000,
      17'h0_0000, 17'h1_7FFF, 17'h1_00FF, 17'h1_FF00,
      17'h0_5555, 17'h1_5555, 17'h1_AAAA, 17'h1_0F0F
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         out_valid;
   logic [W-1:0] out_data;

   int n_chk = 0;
   int n_fail = 0;
   logic         hv [3];
   logic [W-1:0] hd [3];
   logic [W-1:0] last_res;

   always #(CLK_PERIOD/2) clk = ~clk;

   ilv2_slow_unit dut_i (
      .clk(clk),
      .rst(rst),
      .in_valid(in_valid),
      .in_data(in_data),
      .out_valid(out_valid),
      .out_data(out_data)
   );

   function automatic logic [W-1:0] ref_f(input logic [W-1:0] x);
      logic [31:0] t;
      t = 32'(x) * 32'(x) + 32'd37 * 32'(x) + 32'h1234;
      return t[W-1:0];
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int i = 0; i < 3; i++) begin
         hv[i] = 1'b0;
         hd[i] = '0;
      end
      last_res = '0;
   endtask

   // checks the result due now (operand driven three negedges ago), then drives
   task automatic step(input logic v, input logic [W-1:0] d, input string tag);
      @(negedge clk);
      chk("R4", W'(out_valid), W'(hv[2]), "out_valid");
      if (hv[2]) begin
         chk(tag, out_data, ref_f(hd[2]), "out_data");
         last_res = ref_f(hd[2]);
      end else begin
         chk("R7", out_data, last_res, "held out_data");
      end
      in_valid = v;
      in_data  = d;
      hv[2] = hv[1]; hd[2] = hd[1];
      hv[1] = hv[0]; hd[1] = hd[0];
      hv[0] = v;     hd[0] = d;
   endtask

   task automatic do_reset(input int n);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
      rst = 1'b0;
      clear_hist();
      chk("R2", W'(out_valid), '0, "out_valid after reset");
      chk("R2", out_data, '0, "out_data after reset");
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      clear_hist();
      do_reset(3);

      // R1: table of boundary and mixed operands with gaps
      for (int i = 0; i < NSTIM; i++)
         step(STIM[i][W], STIM[i][W-1:0], "R1");
      repeat (4) step(1'b0, '0, "R5");

      // R6: long back-to-back burst keeps both copies busy
      for (int i = 0; i < 12; i++)
         step(1'b1, W'(i * 4099 + 7), "R6");
      repeat (4) step(1'b0, '0, "R6");

      // R3: single gaps between valid operands
      for (int i = 0; i < 8; i++) begin
         step(1'b1, W'(16'hC000 + i * 311), "R3");
         step(1'b0, 16'hDEAD, "R3");
      end
      repeat (3) step(1'b0, '0, "R3");

      // R5: irregular gap pattern, order must be preserved
      step(1'b1, 16'h0102, "R5");
      step(1'b1, 16'h0304, "R5");
      step(1'b0, 16'hFFFF, "R5");
      step(1'b1, 16'h0506, "R5");
      step(1'b0, 16'h0000, "R5");
      step(1'b0, 16'h0000, "R5");
      step(1'b1, 16'h0708, "R5");
      step(1'b1, 16'h090A, "R5");
      step(1'b1, 16'h0B0C, "R5");
      repeat (4) step(1'b0, '0, "R5");

      // R2: reset with operands in flight drops them
      step(1'b1, 16'h4444, "R2");
      step(1'b1, 16'h5555, "R2");
      do_reset(2);
      repeat (4) step(1'b0, '0, "R2");

      // R1: operation resumes correctly after reset
      step(1'b1, 16'h2468, "R1");
      step(1'b1, 16'h1357, "R1");
      step(1'b1, 16'hFFFE, "R1");
      repeat (4) step(1'b0, '0, "R1");

      summary();
      $finish;
   end
endmodule